// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write an external 8K x 8 asynchronous static RAM. The host side is a simple request/ready handshake. The host presents a 13-bit address, a write flag and 8-bit write data. Read data comes back with a one-cycle valid strobe. The memory side drives a low-active select and a high-active select, a low-active output enable, a low-active write enable and the address lines. It also drives a bidirectional data bus, which is split into separate outgoing data, incoming data and drive-enable signals. The pad ring combines them.

Every access is a fixed sequence of clock cycles. The number of cycles in each phase is computed at elaboration time as ceiling(limit / clock period), with a minimum of one. The limits used are the memory's minimum times:

- address access: 80 ns
- output-enable access: 40 ns
- cycle time: 80 ns
- write pulse: 60 ns
- data setup: 40 ns
- select-to-end-of-write: 70 ns
- address-to-end-of-write: 70 ns

With the default 8 ns clock, a read holds its phase for 10 cycles and a write holds its phase for 10 cycles. A write that follows a read first spends one turnaround cycle with the memory deselected. This lets the memory's output drivers turn off before the controller drives the bus.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset and whenever idle: memCe1N=1, memCe2=0, memOeN=1, memWeN=1, memDataOe=0, ready=1 and rdValid=0.
- R2: A request is taken only at a clock edge where ready and reqValid are both 1. ready is 0 from the next cycle until the access finishes. reqValid raised while ready is 0 has no effect.
- R3: A read holds memCe1N=0, memCe2=1, memOeN=0 and memWeN=1 for RD_CYC cycles (10 at default settings). It samples memDataIn at the edge that ends the last of those cycles. The next cycle shows ready=1 together with rdValid=1 and the sampled byte on rdData. rdValid lasts one cycle. From the accepting edge to ready is RD_CYC cycles.
- R4: A write holds memCe1N=0, memCe2=1, memWeN=0, memOeN=1 and memDataOe=1 with the write byte on memDataOut for WR_CYC cycles (10 at default settings). From the accepting edge to ready is WR_CYC cycles when no turnaround applies.
- R5: memAddr carries the accepted address for the whole access and keeps it until the next request is taken.
- R6: memDataOe is never 1 while memOeN is 0.
- R7: A write whose preceding completed access was a read first spends one cycle fully deselected with the bus released. Its latency is therefore WR_CYC+1 cycles.
- R8: Raising rst during an access returns the block to the idle state of R1 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 13 | Host address |
| reqWdata | input | 8 | Host write data |
| ready | output | 1 | Controller idle and able to take a request |
| rdData | output | 8 | Last read byte |
| rdValid | output | 1 | One-cycle strobe marking fresh rdData |
| memCe1N | output | 1 | Memory select, active low |
| memCe2 | output | 1 | Memory select, active high |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memAddr | output | 13 | Memory address lines |
| memDataOut | output | 8 | Data toward the memory |
| memDataIn | input | 8 | Data from the memory |
| memDataOe | output | 1 | Drive enable for memDataOut |

## Verification
The memory model returns a poison byte until ten full cycles of select with output enable low have passed. A controller that samples one cycle early therefore reads back poison instead of stored data. The model commits a write only when write enable has stayed low for exactly the expected ten cycles, with the address stable and the data driven throughout. A short pulse or a moving address shows up as lost data and a model error.

A read-then-write pair is timed to catch a missing turnaround cycle. A request waved in during a busy read is followed by a readback, which catches a controller that accepts while busy. A reset mid-read must leave the bus released and the memory deselected at once.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WRITE
  } ctlState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadReq;
    logic select;
    logic oeOn;
    logic weOn;
    logic driveOn;
    logic capture;
  } strobes_t;

  function automatic int cyclesFor(input int limitNs, input int periodNs);
    int c;
    c = (limitNs + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC = 10,
  parameter int WR_CYC = 10,
  parameter int CNT_W  = 5
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     ready,
  output strobes_t strobes
);

  ctlState_e         state;
  logic [CNT_W-1:0]  phaseCnt;
  logic              lastWasRead;

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      phaseCnt    <= '0;
      lastWasRead <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          phaseCnt <= '0;
          if (reqValid) begin
            if (!reqWrite)        state <= ST_READ;
            else if (lastWasRead) state <= ST_TURN;
            else                  state <= ST_WRITE;
          end
        end
        ST_TURN: begin
          phaseCnt <= '0;
          state    <= ST_WRITE;
        end
        ST_READ: begin
          if (phaseCnt == RD_LAST) begin
            state       <= ST_IDLE;
            lastWasRead <= 1'b1;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_WRITE: begin
          if (phaseCnt == WR_LAST) begin
            state       <= ST_IDLE;
            lastWasRead <= 1'b0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ready           = (state == ST_IDLE);
    strobes.loadReq = (state == ST_IDLE) && reqValid;
    strobes.select  = (state == ST_READ) || (state == ST_WRITE);
    strobes.oeOn    = (state == ST_READ);
    strobes.weOn    = (state == ST_WRITE);
    strobes.driveOn = (state == ST_WRITE);
    strobes.capture = (state == ST_READ) && (phaseCnt == RD_LAST);
  end

  // R2: an accepted request makes the controller busy on the next cycle
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (ready && reqValid) |=> !ready);

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int RD_CYC = 10,
  parameter int WR_CYC = 10,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              memDataOe
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (strobes.loadReq) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (strobes.capture) rdData <= memDataIn;
      rdValid <= strobes.capture;
    end
  end

  always_comb begin
    memCe1N    = ~strobes.select;
    memCe2     = strobes.select;
    memOeN     = ~strobes.oeOn;
    memWeN     = ~strobes.weOn;
    memAddr    = addrReg;
    memDataOut = wdataReg;
    memDataOe  = strobes.driveOn;
  end

  // Pin-level phase counters for the timing checks below.
  logic [CNT_W-1:0] weLowCnt;
  logic [CNT_W-1:0] oeLowCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      weLowCnt <= '0;
      oeLowCnt <= '0;
    end else begin
      if (!memWeN) weLowCnt <= (weLowCnt == '1) ? weLowCnt : weLowCnt + 1'b1;
      else         weLowCnt <= '0;
      if (!memOeN && !memCe1N) oeLowCnt <= (oeLowCnt == '1) ? oeLowCnt : oeLowCnt + 1'b1;
      else                     oeLowCnt <= '0;
    end
  end

  // R4: write-enable pulse spans the full write phase
  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (weLowCnt >= CNT_W'(WR_CYC)));

  // R3: read data sampled only after the whole access window
  assert_capture_late_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |-> (oeLowCnt >= CNT_W'(RD_CYC - 1)));

  // R6: never drive the bus while the memory may drive it
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (rst)
    memDataOe |-> memOeN);

  // R5: address steady while the memory stays selected
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!memCe1N && $past(!memCe1N)) |-> $stable(memAddr));

  // R7: output enable high for two cycles before the bus is driven
  assert_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(memDataOe) |-> ($past(memOeN, 1) && $past(memOeN, 2)));

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_ADDR_ACC_NS = 80,
  parameter int T_OE_ACC_NS   = 40,
  parameter int T_CYCLE_NS    = 80,
  parameter int T_WE_PULSE_NS = 60,
  parameter int T_DSETUP_NS   = 40,
  parameter int T_SEL_END_NS  = 70,
  parameter int T_ADR_END_NS  = 70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              memDataOe
);

  localparam int RD_CYC = maxOf(maxOf(cyclesFor(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                      cyclesFor(T_OE_ACC_NS, CLK_PERIOD_NS)),
                                cyclesFor(T_CYCLE_NS, CLK_PERIOD_NS));
  localparam int WR_CYC = maxOf(maxOf(maxOf(cyclesFor(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                            cyclesFor(T_DSETUP_NS, CLK_PERIOD_NS)),
                                      maxOf(cyclesFor(T_SEL_END_NS, CLK_PERIOD_NS),
                                            cyclesFor(T_ADR_END_NS, CLK_PERIOD_NS))),
                                cyclesFor(T_CYCLE_NS, CLK_PERIOD_NS));
  localparam int CNT_W  = $clog2(maxOf(RD_CYC, WR_CYC) + 1) + 1;

  strobes_t strobes;

  sram_ctl_fsm #(
    .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .CNT_W(CNT_W)
  ) i_fsm (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .ready(ready), .strobes(strobes)
  );

  sram_ctl_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .CNT_W(CNT_W)
  ) i_datapath (
    .clk(clk), .rst(rst), .strobes(strobes), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdData(rdData), .rdValid(rdValid), .memCe1N(memCe1N), .memCe2(memCe2),
    .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataIn(memDataIn), .memDataOe(memDataOe)
  );

  // R1: idle means memory deselected and bus released
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    ready |-> (memCe1N && !memCe2 && memOeN && memWeN && !memDataOe));

  // R3: read-valid strobe lasts a single cycle and only while ready
  assert_rdvalid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> (ready && $past(!ready)));

endmodule

// File: tb/test_sram_async_ctl.sv
module test_sram_async_ctl;

  localparam int RD_LAT = 10;
  localparam int WR_LAT = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        ready, rdValid;
  logic [7:0]  rdData;
  logic        memCe1N, memCe2, memOeN, memWeN, memDataOe;
  logic [12:0] memAddr;
  logic [7:0]  memDataOut, memDataIn;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  sram_async_ctl i_sram_async_ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ready(ready), .rdData(rdData),
    .rdValid(rdValid), .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN),
    .memWeN(memWeN), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataIn(memDataIn), .memDataOe(memDataOe)
  );

  // Memory model: slow reads and strict write pulses.
  logic [7:0]  mem [0:8191];
  int          rdCnt, wrCnt, modelErr, contention;
  logic [12:0] pendAddr;
  logic [7:0]  pendData;
  logic        selOn, readOn, writeOn;

  assign selOn   = !memCe1N && memCe2;
  assign readOn  = selOn && !memOeN && memWeN;
  assign writeOn = selOn && !memWeN;
  assign memDataIn = (readOn && rdCnt >= RD_LAT - 1) ? mem[memAddr] : 8'h5A;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8192; i++) mem[i] <= 8'(i) ^ 8'h3C;
      rdCnt <= 0; wrCnt <= 0; modelErr <= 0; contention <= 0;
    end else begin
      rdCnt <= readOn ? rdCnt + 1 : 0;
      if (memDataOe && readOn) contention <= contention + 1;
      if (writeOn) begin
        if (wrCnt != 0 && memAddr != pendAddr) modelErr <= modelErr + 1;
        if (!memDataOe) modelErr <= modelErr + 1;
        pendAddr <= memAddr;
        pendData <= memDataOut;
        wrCnt    <= wrCnt + 1;
      end else if (wrCnt != 0) begin
        if (wrCnt == WR_LAT) mem[pendAddr] <= pendData;
        else modelErr <= modelErr + 1;
        wrCnt <= 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [12:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int lat, output bit rv);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!ready && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    rd = rdData;
    rv = rdValid;
  endtask

  // {write, address, data}; for reads data is the expected byte.
  localparam logic [21:0] VEC [0:7] = '{
    {1'b1, 13'h0000, 8'hA1},
    {1'b1, 13'h1FFF, 8'h5E},
    {1'b0, 13'h0000, 8'hA1},
    {1'b0, 13'h1FFF, 8'h5E},
    {1'b1, 13'h0ABC, 8'h33},
    {1'b1, 13'h0ABD, 8'hC4},
    {1'b0, 13'h0ABC, 8'h33},
    {1'b0, 13'h0123, 8'h1F}
  };

  initial begin : watchdog
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lat;
    bit rv;
    bit prevRead;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(memCe1N && !memCe2 && memOeN && memWeN && !memDataOe && ready && !rdValid,
          "R1", "idle pins after reset",
          {memCe1N, memCe2, memOeN, memWeN, memDataOe, ready, rdValid}, 7'b1011010);

    prevRead = 1'b0;
    for (int v = 0; v < 8; v++) begin
      bit wr;
      wr = VEC[v][21];
      access(wr, VEC[v][20:8], VEC[v][7:0], rd, lat, rv);
      if (wr) begin
        if (prevRead) check(lat == WR_LAT + 1, "R7", "write latency after read", lat, WR_LAT + 1);
        else          check(lat == WR_LAT, "R4", "write latency", lat, WR_LAT);
      end else begin
        check(lat == RD_LAT, "R3", "read latency", lat, RD_LAT);
        check(rv == 1'b1, "R3", "rdValid with ready", rv, 1);
        check(rd == VEC[v][7:0], "R3", "read data", rd, VEC[v][7:0]);
        @(negedge clk);
        check(rdValid == 1'b0, "R3", "rdValid single cycle", rdValid, 0);
      end
      prevRead = !wr;
    end

    // R5: address held after access and during next one
    check(memAddr == 13'h0123, "R5", "address held while idle", memAddr, 13'h0123);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 13'h0042;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 13'h1111;
    repeat (4) @(negedge clk);
    check(memAddr == 13'h0042, "R5", "address during read", memAddr, 13'h0042);
    check(!memOeN && memWeN && !memCe1N && memCe2, "R3", "read pin levels",
          {memCe1N, memCe2, memOeN, memWeN}, 4'b0101);
    // R2: request raised while busy must be ignored
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 13'h0077; reqWdata = 8'hEE;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    check(!ready, "R2", "busy during access", ready, 0);
    while (!ready) @(negedge clk);
    check(rdData == (8'h42 ^ 8'h3C), "R3", "read data default", rdData, 8'h42 ^ 8'h3C);
    access(1'b0, 13'h0077, 8'h00, rd, lat, rv);
    check(rd == (8'h77 ^ 8'h3C), "R2", "busy request ignored", rd, 8'h77 ^ 8'h3C);

    // R4: write pin levels mid-phase (write after write, no turnaround)
    access(1'b1, 13'h0005, 8'h99, rd, lat, rv);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 13'h0006; reqWdata = 8'h66;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    check(!memWeN && memOeN && memDataOe && memDataOut == 8'h66 && !memCe1N && memCe2,
          "R4", "write pin levels", {memWeN, memOeN, memDataOe, memDataOut}, {3'b011, 8'h66});
    while (!ready) @(negedge clk);
    access(1'b0, 13'h0006, 8'h00, rd, lat, rv);
    check(rd == 8'h66, "R4", "second write stored", rd, 8'h66);

    check(contention == 0, "R6", "bus contention cycles", contention, 0);
    check(modelErr == 0, "R4", "write timing errors", modelErr, 0);

    // R8: reset mid-read
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 13'h0010;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(memCe1N && !memCe2 && memOeN && memWeN && !memDataOe && ready,
          "R8", "idle after mid-access reset",
          {memCe1N, memCe2, memOeN, memWeN, memDataOe, ready}, 6'b101101);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule